// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block executes stack-machine instructions one at a time. Each instruction is an opcode and an optional data-memory address. ADD, SUB and MUL name no operands. Each one takes the two uppermost stack entries, removes both, and leaves a single result on top. PUSH reads a word from the external data memory onto the stack. POP writes the top word out to the external data memory. The stack lives in a small register array inside the block. It grows toward lower slot indices, and a stack pointer names the occupied top slot.

An instruction is offered with a valid/ready handshake. While the unit is busy, ready stays low. A one-cycle done pulse marks completion. The current top-of-stack word and a flag saying whether the stack holds anything are always visible. A binary operation with too few operands, a POP from an empty stack and a PUSH onto a full stack do not change any state. Each one raises a sticky error flag instead. The data memory port is word addressed. A read returns its data one cycle after the request.

Top module: `zstack_unit`

## Requirements
- R1: After synchronous active-high reset the stack is empty: tos_valid is 0, tos is 0, both error flags are 0 and instr_ready is 1.
- R2: An instruction is taken on a clock edge where instr_valid and instr_ready are both 1. instr_ready is 0 from the next cycle until completion. done is a single-cycle pulse that appears 2 cycles after the accepting edge, or 3 cycles for a PUSH that reads memory.
- R3: Opcode 0 (ADD) removes the two uppermost entries and pushes their sum modulo 2^16, so depth drops by one.
- R4: Opcode 1 (SUB) pushes the entry below the top minus the top entry, modulo 2^16.
- R5: Opcode 2 (MUL) pushes the low 16 bits of the product of the two uppermost entries.
- R6: Opcode 3 (PUSH) performs exactly one memory read at the instruction address. The word read becomes the new top, and depth rises by one.
- R7: Opcode 4 (POP) performs exactly one memory write of the top word to the instruction address, and depth drops by one.
- R8: The sequence PUSH A, PUSH B, ADD, PUSH C, PUSH D, ADD, MUL, POP X stores (A+B)*(C+D) modulo 2^16 at X and restores the stack to its starting depth.
- R9: A binary opcode with fewer than two entries, or a POP on an empty stack, sets err_underflow. The flag stays set until reset. The stack is left unchanged and no memory access occurs.
- R10: A PUSH when all 16 slots are occupied sets err_overflow. The flag stays set until reset. The stack is left unchanged and no memory access occurs.
- R11: Opcodes 5, 6 and 7 complete with done and change no stack state and no flag.
- R12: mem_we is only asserted together with mem_req, and memory is only accessed while instr_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle and able to take an instruction |
| instr_op | input | 3 | Opcode: 0 ADD, 1 SUB, 2 MUL, 3 PUSH, 4 POP |
| instr_addr | input | AW (8) | Data memory word address for PUSH and POP |
| done | output | 1 | One-cycle completion pulse |
| tos | output | DW (16) | Current top-of-stack word, 0 when empty |
| tos_valid | output | 1 | Stack holds at least one entry |
| err_underflow | output | 1 | Sticky underflow flag |
| err_overflow | output | 1 | Sticky overflow flag |
| mem_req | output | 1 | Data memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (8) | Data memory word address |
| mem_wdata | output | DW (16) | Data memory write word |
| mem_rdata | input | DW (16) | Data memory read word, valid one cycle after a read request |

## Verification
A stack pointer that drifts shows up at tos and tos_valid on the very done pulse of the instruction that moved it. It shows up later as a false underflow or overflow, or as a missing one. A slot written at the wrong index stays hidden until the stack unwinds to it. The bench therefore compares tos after every instruction, counts memory requests per instruction, and reads back every POP target. A wrong operand order or result width appears at tos on the done pulse of that operation.

// File: rtl/zs_pkg.sv
package zs_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_PUSH = 3'd3,
        OP_POP  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_FILL = 2'd2
    } state_e;

endpackage

// File: rtl/zs_alu.sv
module zs_alu
    import zs_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] below,
    input  logic [DW-1:0] top,
    output logic [DW-1:0] result
);

    // Operand order follows push order: the entry pushed first is the left operand.
    always_comb begin
        case (op)
            OP_ADD:  result = below + top;
            OP_SUB:  result = below - top;
            OP_MUL:  result = below * top;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/zs_stack.sv
module zs_stack #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int SPW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [SPW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic [SPW-1:0] rd_idx_a,
    input  logic [SPW-1:0] rd_idx_b,
    output logic [DW-1:0]  rd_data_a,
    output logic [DW-1:0]  rd_data_b
);

    logic [DEPTH-1:0][DW-1:0] slots;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == SPW'(g))) begin
                cell_q <= wr_data;
            end
        end
        assign slots[g] = cell_q;
    end

    // An index at or past DEPTH reads as zero.
    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_a == SPW'(i)) rd_data_a = slots[i];
            if (rd_idx_b == SPW'(i)) rd_data_b = slots[i];
        end
    end

endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
    import zs_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 16,
    parameter int SPW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           instr_valid,
    input  logic [2:0]     instr_op,
    input  logic [AW-1:0]  instr_addr,
    output logic           instr_ready,
    output logic           done,
    output logic           err_underflow,
    output logic           err_overflow,
    output logic           stk_empty,
    output logic [SPW-1:0] sp,
    output op_e            alu_op,
    output logic           stk_we,
    output logic [SPW-1:0] stk_widx,
    output logic           stk_from_mem,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr
);

    localparam logic [SPW-1:0] SP_EMPTY = SPW'(DEPTH);
    localparam logic [SPW-1:0] SP_FULL  = '0;
    localparam logic [SPW-1:0] SP_TWO   = SPW'(DEPTH - 2);

    typedef struct packed {
        state_e         st;
        op_e            op;
        logic [AW-1:0]  addr;
        logic [SPW-1:0] sp;
        logic           unf;
        logic           ovf;
        logic           done;
    } ctl_t;

    ctl_t q, d;

    logic is_empty, is_full, has_two;

    assign is_empty = (q.sp == SP_EMPTY);
    assign is_full  = (q.sp == SP_FULL);
    assign has_two  = (q.sp <= SP_TWO);

    always_comb begin
        d            = q;
        d.done       = 1'b0;
        stk_we       = 1'b0;
        stk_widx     = q.sp;
        stk_from_mem = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    d.st   = ST_EXEC;
                    d.op   = op_e'(instr_op);
                    d.addr = instr_addr;
                end
            end
            ST_EXEC: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                case (q.op)
                    OP_ADD, OP_SUB, OP_MUL: begin
                        if (has_two) begin
                            // result overwrites the lower operand slot
                            stk_we   = 1'b1;
                            stk_widx = q.sp + SPW'(1);
                            d.sp     = q.sp + SPW'(1);
                        end else begin
                            d.unf = 1'b1;
                        end
                    end
                    OP_PUSH: begin
                        if (is_full) begin
                            d.ovf = 1'b1;
                        end else begin
                            mem_req = 1'b1;
                            d.st    = ST_FILL;
                            d.done  = 1'b0;
                        end
                    end
                    OP_POP: begin
                        if (is_empty) begin
                            d.unf = 1'b1;
                        end else begin
                            mem_req = 1'b1;
                            mem_we  = 1'b1;
                            d.sp    = q.sp + SPW'(1);
                        end
                    end
                    default: ;
                endcase
            end
            ST_FILL: begin
                // pre-decrement, then write the word returned by memory
                stk_we       = 1'b1;
                stk_widx     = q.sp - SPW'(1);
                stk_from_mem = 1'b1;
                d.sp         = q.sp - SPW'(1);
                d.st         = ST_IDLE;
                d.done       = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= ST_IDLE;
            q.op   <= OP_ADD;
            q.addr <= '0;
            q.sp   <= SP_EMPTY;
            q.unf  <= 1'b0;
            q.ovf  <= 1'b0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign instr_ready   = (q.st == ST_IDLE);
    assign done          = q.done;
    assign err_underflow = q.unf;
    assign err_overflow  = q.ovf;
    assign stk_empty     = is_empty;
    assign sp            = q.sp;
    assign alu_op        = q.op;
    assign mem_addr      = q.addr;

endmodule

// File: rtl/zstack_unit.sv
module zstack_unit
    import zs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    output logic          instr_ready,
    input  logic [2:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    output logic          done,
    output logic [DW-1:0] tos,
    output logic          tos_valid,
    output logic          err_underflow,
    output logic          err_overflow,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int SPW = $clog2(DEPTH + 1);

    logic [SPW-1:0] sp;
    logic           stk_empty;
    op_e            alu_op;
    logic           stk_we;
    logic [SPW-1:0] stk_widx;
    logic           stk_from_mem;
    logic [DW-1:0]  top_w, below_w, alu_y, stk_wdata;

    zs_ctrl #(
        .AW    (AW),
        .DEPTH (DEPTH),
        .SPW   (SPW)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .instr_op      (instr_op),
        .instr_addr    (instr_addr),
        .instr_ready   (instr_ready),
        .done          (done),
        .err_underflow (err_underflow),
        .err_overflow  (err_overflow),
        .stk_empty     (stk_empty),
        .sp            (sp),
        .alu_op        (alu_op),
        .stk_we        (stk_we),
        .stk_widx      (stk_widx),
        .stk_from_mem  (stk_from_mem),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr)
    );

    zs_stack #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .SPW   (SPW)
    ) u_stack (
        .clk       (clk),
        .wr_en     (stk_we),
        .wr_idx    (stk_widx),
        .wr_data   (stk_wdata),
        .rd_idx_a  (sp),
        .rd_idx_b  (sp + SPW'(1)),
        .rd_data_a (top_w),
        .rd_data_b (below_w)
    );

    zs_alu #(
        .DW (DW)
    ) u_alu (
        .op     (alu_op),
        .below  (below_w),
        .top    (top_w),
        .result (alu_y)
    );

    assign stk_wdata = stk_from_mem ? mem_rdata : alu_y;
    assign mem_wdata = top_w;
    assign tos_valid = ~stk_empty;
    assign tos       = stk_empty ? '0 : top_w;

endmodule

// File: rtl/zs_chk.sv
module zs_chk (
    input logic clk,
    input logic rst,
    input logic instr_valid,
    input logic instr_ready,
    input logic done,
    input logic tos_valid,
    input logic err_underflow,
    input logic err_overflow,
    input logic mem_req,
    input logic mem_we
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!err_underflow && !err_overflow && !tos_valid && instr_ready));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready) |=> !instr_ready);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> instr_ready);

    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_underflow |=> err_underflow);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_overflow |=> err_overflow);

    // R12
    we_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R12
    mem_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !instr_ready);

endmodule

bind zstack_unit zs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .done          (done),
    .tos_valid     (tos_valid),
    .err_underflow (err_underflow),
    .err_overflow  (err_overflow),
    .mem_req       (mem_req),
    .mem_we        (mem_we)
);

// File: tb/sim_zstack_unit.sv
module sim_zstack_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [2:0]  instr_op = 3'd0;
    logic [7:0]  instr_addr = 8'd0;
    logic        done;
    logic [15:0] tos;
    logic        tos_valid;
    logic        err_underflow, err_overflow;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    always #5 clk = ~clk;

    zstack_unit u0 (
        .clk (clk), .rst (rst),
        .instr_valid (instr_valid), .instr_ready (instr_ready),
        .instr_op (instr_op), .instr_addr (instr_addr),
        .done (done), .tos (tos), .tos_valid (tos_valid),
        .err_underflow (err_underflow), .err_overflow (err_overflow),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    function automatic logic [15:0] ival(int i);
        return 16'((i * 40503 + 4099) ^ (i << 7));
    endfunction

    // data memory model: one-cycle read latency, reloaded on reset
    logic [15:0] bmem [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bmem[i] <= ival(i);
        end else if (mem_req) begin
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr];
        end
    end

    int nreq = 0;
    always @(posedge clk) if (!rst && mem_req) nreq++;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // reference model
    logic [15:0] rs [16];
    int          cnt;
    bit          eu, eo;
    logic [15:0] mm [256];

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cnt = 0; eu = 0; eo = 0;
        for (int i = 0; i < 256; i++) mm[i] = ival(i);
        @(negedge clk);
        // R1
        chk(!tos_valid && tos == 16'd0, "R1", "empty after reset", {tos_valid, tos}, 0);
        chk(!err_underflow && !err_overflow, "R1", "flags after reset",
            {err_underflow, err_overflow}, 0);
        chk(instr_ready, "R1", "ready after reset", instr_ready, 1);
    endtask

    task automatic run(int op, int addr);
        int lat, nexp, waited, req0;
        string tag;
        logic [15:0] a, b, r;
        lat = 2; nexp = 0;
        case (op)
            0, 1, 2: begin
                tag = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
                if (cnt < 2) begin eu = 1; tag = "R9"; end
                else begin
                    a = rs[cnt-2]; b = rs[cnt-1];
                    r = (op == 0) ? a + b : (op == 1) ? a - b : 16'(a * b);
                    cnt--; rs[cnt-1] = r;
                end
            end
            3: begin
                tag = "R6";
                if (cnt == 16) begin eo = 1; tag = "R10"; end
                else begin rs[cnt] = mm[addr]; cnt++; lat = 3; nexp = 1; end
            end
            4: begin
                tag = "R7";
                if (cnt == 0) begin eu = 1; tag = "R9"; end
                else begin mm[addr] = rs[cnt-1]; cnt--; nexp = 1; end
            end
            default: tag = "R11";
        endcase
        @(negedge clk);
        instr_valid = 1'b1; instr_op = 3'(op); instr_addr = 8'(addr);
        while (!instr_ready) @(negedge clk);
        req0 = nreq;
        @(posedge clk);
        #1 instr_valid = 1'b0;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!done && waited < 20);
        chk(waited == lat, "R2", "done latency", waited, lat);
        chk(tos_valid == (cnt > 0), tag, "tos_valid", tos_valid, cnt > 0);
        chk(tos == ((cnt > 0) ? rs[cnt-1] : 16'd0), tag, "tos", tos,
            (cnt > 0) ? rs[cnt-1] : 0);
        chk(err_underflow == eu, "R9", "underflow flag", err_underflow, eu);
        chk(err_overflow == eo, "R10", "overflow flag", err_overflow, eo);
        chk(nreq - req0 == nexp, tag, "memory accesses", nreq - req0, nexp);
        if (op == 4) chk(bmem[addr] == mm[addr], tag, "popped word", bmem[addr], mm[addr]);
    endtask

    initial begin
        logic [15:0] xv;
        void'($urandom(32'd2024));
        do_reset();

        // R8: expression sequence
        run(3, 10); run(3, 11); run(0, 0);
        run(3, 12); run(3, 13); run(0, 0);
        run(2, 0); run(4, 20);
        xv = 16'((ival(10) + ival(11)) * (ival(12) + ival(13)));
        chk(bmem[20] == xv, "R8", "expression result", bmem[20], xv);
        chk(!tos_valid, "R8", "depth restored", tos_valid, 0);

        // R4: operand order
        run(3, 5); run(3, 6); run(1, 0);
        chk(tos == 16'(ival(5) - ival(6)), "R4", "sub order", tos, 16'(ival(5) - ival(6)));
        run(4, 30);

        // R11: undefined opcodes
        run(3, 7); run(5, 0); run(6, 0); run(7, 0);
        run(4, 31);

        // R9: underflow cases
        run(0, 0); run(4, 40);
        do_reset();
        run(3, 1); run(2, 0);
        do_reset();

        // R10: fill then overflow
        for (int i = 0; i < 17; i++) run(3, 100 + i);
        // R5: truncating multiply at the full stack
        run(2, 0);
        do_reset();

        for (int round = 0; round < 4; round++) begin
            for (int k = 0; k < 150; k++) begin
                int x, op;
                x = int'($urandom % 16);
                if (x < 6) op = 3;
                else if (x < 9) op = 4;
                else if (x < 11) op = 0;
                else if (x < 13) op = 1;
                else if (x < 15) op = 2;
                else op = 5 + int'($urandom % 3);
                run(op, int'($urandom % 256));
            end
            do_reset();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule